// File: doc/BRIEF.md
# Flash Page Program and Erase Sequencer

This block drives a flash controller's command port through a complete page program or page erase, so a client only has to raise a request and wait for one completion pulse. A program request unlocks the page's region, erases the page, clears the controller's page buffer, streams the new page contents into the buffer, and commits them with a write-page command. An erase request stops after the erase. When either operation succeeds, the block sends a one-cycle cache invalidate so that stale copies of the page are dropped.

Each command carries a fixed key and a six-bit command code. Some steps complete when the controller raises a one-cycle ready event. The short steps, which are clearing the buffer and enabling high-speed mode, are polled on the ready level instead. If a lock error or a programming error is present when any step completes, the operation is abandoned and reported as failed. The very first accepted request is preceded by a one-time configuration step. A request that arrives while an operation is running is turned away in the same cycle.

Page data comes from a client-side source that is indexed by word. The page holds 512 bytes and is moved as 64 eight-byte words. Every word is written twice into the buffer: first as all ones, then with the real data.

Top module: `flash_page_seq`

## Requirements
- R1: A program request issues, in this order, unlock (code 5, latched page), erase (code 2, latched page), buffer clear (code 3, page field 0), the buffer fill, and write-page (code 1, latched page). Every command has key 0xA5 and no two commands are issued in consecutive cycles.
- R2: An erase request issues unlock (code 5) and then erase (code 2), both for the latched page. It makes no buffer writes.
- R3: A write or erase strobe seen while `seqIdle` is low raises `reqReject` in that same cycle and is otherwise ignored: no extra commands, no buffer writes, and the running page is unchanged. A strobe seen while idle is accepted, and `seqIdle` falls on the next cycle.
- R4: When a step completes with `lockErr` or `progErr` high, no further commands or buffer writes follow. `done` pulses with `doneOk`=0 and `cacheInval` stays low. The next request runs normally.
- R5: The fill makes exactly 128 buffer writes, two for each word index i from 0 to 63, at byte address page*512 + 8*i. The first write of each pair carries all ones. The second carries `srcData` while `srcIdx` equals i.
- R6: Unlock, erase and write-page complete only on a `readyEvt` pulse; `flashReady` being high does not advance them. Buffer clear and high-speed enable complete on the `flashReady` level.
- R7: The first accepted request is preceded by one `cfgWrite` pulse (with `cfgWaitState` = the WAIT_STATE parameter) and a polled high-speed command (code 16). Later requests skip both.
- R8: `cacheInval` is a one-cycle pulse. It occurs only when an operation succeeds, in the same cycle as `done` with `doneOk`=1.
- R9: `done` is a one-cycle pulse, and `seqIdle` is already high in that cycle. `doneOk` is 0 whenever `done` is 0.
- R10: When both strobes are high at once, the request is treated as a program.
- R11: After reset the block is idle and unconfigured, with `done`, `cmdValid`, `bufWr`, `cfgWrite` and `cacheInval` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqWrite | input | 1 | Program request strobe |
| reqErase | input | 1 | Erase request strobe |
| reqPage | input | PAGE_W | Page number for the request |
| reqReject | output | 1 | Request refused because the block is busy |
| seqIdle | output | 1 | Block ready for a request |
| done | output | 1 | Operation finished (one cycle) |
| doneOk | output | 1 | Operation succeeded, valid with done |
| srcIdx | output | 6 | Word index into the client page data |
| srcData | input | 64 | Client page word at srcIdx |
| cmdValid | output | 1 | Command strobe to the flash controller |
| cmdKey | output | 8 | Command key, always 0xA5 |
| cmdCode | output | 6 | Command code |
| cmdPage | output | PAGE_W | Command page field |
| flashReady | input | 1 | Controller ready level (polled steps) |
| readyEvt | input | 1 | Controller completion event pulse |
| lockErr | input | 1 | Lock error flag |
| progErr | input | 1 | Programming error flag |
| bufWr | output | 1 | Page buffer write strobe |
| bufAddr | output | PAGE_W+9 | Page buffer byte address |
| bufData | output | 64 | Page buffer write data |
| cfgWrite | output | 1 | Configuration write strobe (interrupt enables cleared) |
| cfgWaitState | output | 1 | Wait-state value for the configuration write |
| cacheInval | output | 1 | Cache invalidate pulse |

## Verification
Program requests use a low page, the all-ones top page, and a page given with both strobes high. Together these show that the command order is right, that the latched page reaches the command and address fields, and that program wins over erase. Erase requests show the shorter chain and the absence of buffer traffic. Errors are injected at unlock, buffer clear and write-page, which covers the event-driven and the polled completion paths and shows that the abort stops exactly where the error occurred. A slow ready event, with `flashReady` held high the whole time, shows that the event-driven steps ignore the ready level. A request made in the middle of an operation shows that the refusal leaves the running operation untouched.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  localparam logic [7:0] CMD_KEY = 8'hA5;

  typedef enum logic [5:0] {
    CMD_NOP    = 6'd0,
    CMD_WRITE  = 6'd1,
    CMD_ERASE  = 6'd2,
    CMD_CLRBUF = 6'd3,
    CMD_UNLOCK = 6'd5,
    CMD_HSPEED = 6'd16
  } cmdCode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CFG, S_HS, S_HS_W,
    S_UNLK, S_UNLK_W, S_ERS, S_ERS_W,
    S_CLR, S_CLR_W, S_FILL, S_WRT, S_WRT_W
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     cntClr;
    logic     cntStep;
    logic     issue;
    cmdCode_t code;
    logic     bufWr;
    logic     cfgWr;
  } seqStrobes_t;

endpackage

// File: rtl/fsq_datapath.sv
module fsq_datapath
  import fsq_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int PAGE_BYTES = 512,
  parameter int WORD_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobes_t           stb,
  input  logic                  reqWrite,
  input  logic [PAGE_W-1:0]     reqPage,
  input  logic [WORD_BYTES*8-1:0] srcData,
  output logic [$clog2(PAGE_BYTES/WORD_BYTES)-1:0] srcIdx,
  output logic                  opIsWrite,
  output logic                  fillLast,
  output logic                  cmdValid,
  output logic [7:0]            cmdKey,
  output logic [5:0]            cmdCode,
  output logic [PAGE_W-1:0]     cmdPage,
  output logic                  bufWr,
  output logic [PAGE_W+$clog2(PAGE_BYTES)-1:0] bufAddr,
  output logic [WORD_BYTES*8-1:0] bufData
);
  localparam int WORDS  = PAGE_BYTES / WORD_BYTES;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int LOW_W  = $clog2(WORD_BYTES);
  localparam int DATA_W = WORD_BYTES * 8;

  logic [PAGE_W-1:0] pageQ;
  logic              isWriteQ;
  logic [IDX_W-1:0]  wordIdx;
  logic              phase;     // 0: all-ones pass, 1: data pass

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ    <= '0;
      isWriteQ <= 1'b0;
      wordIdx  <= '0;
      phase    <= 1'b0;
    end else begin
      if (stb.latchReq) begin
        pageQ    <= reqPage;
        isWriteQ <= reqWrite;
      end
      if (stb.cntClr) begin
        wordIdx <= '0;
        phase   <= 1'b0;
      end else if (stb.cntStep) begin
        phase <= ~phase;
        if (phase) wordIdx <= wordIdx + 1'b1;
      end
    end
  end

  logic codeUsesPage;
  always_comb begin
    codeUsesPage = (stb.code != CMD_CLRBUF) && (stb.code != CMD_HSPEED);
  end

  assign opIsWrite = isWriteQ;
  assign fillLast  = phase && (wordIdx == IDX_W'(WORDS - 1));
  assign srcIdx    = wordIdx;
  assign cmdValid  = stb.issue;
  assign cmdKey    = CMD_KEY;
  assign cmdCode   = stb.code;
  assign cmdPage   = codeUsesPage ? pageQ : '0;
  assign bufWr     = stb.bufWr;
  assign bufAddr   = {pageQ, wordIdx, {LOW_W{1'b0}}};
  assign bufData   = phase ? srcData : {DATA_W{1'b1}};

endmodule

// File: rtl/fsq_control.sv
module fsq_control
  import fsq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqWrite,
  input  logic        reqErase,
  input  logic        flashReady,
  input  logic        readyEvt,
  input  logic        lockErr,
  input  logic        progErr,
  input  logic        opIsWrite,
  input  logic        fillLast,
  output seqStrobes_t stb,
  output logic        reqReject,
  output logic        seqIdle,
  output logic        done,
  output logic        doneOk,
  output logic        cacheInval
);
  seqState_t state, nxt;
  logic configured, markCfg;
  logic finish, finOk, errNow, anyReq;

  always_comb begin
    errNow  = lockErr | progErr;
    anyReq  = reqWrite | reqErase;
    stb     = '0;
    nxt     = state;
    finish  = 1'b0;
    finOk   = 1'b0;
    markCfg = 1'b0;
    case (state)
      S_IDLE: if (anyReq) begin
        stb.latchReq = 1'b1;
        stb.cntClr   = 1'b1;
        nxt          = configured ? S_UNLK : S_CFG;
      end
      S_CFG: begin
        stb.cfgWr = 1'b1;
        nxt       = S_HS;
      end
      S_HS: begin
        stb.issue = 1'b1;
        stb.code  = CMD_HSPEED;
        nxt       = S_HS_W;
      end
      S_HS_W: if (flashReady) begin
        if (errNow) begin
          finish = 1'b1;
          nxt    = S_IDLE;
        end else begin
          markCfg = 1'b1;
          nxt     = S_UNLK;
        end
      end
      S_UNLK: begin
        stb.issue = 1'b1;
        stb.code  = CMD_UNLOCK;
        nxt       = S_UNLK_W;
      end
      S_UNLK_W: if (readyEvt) begin
        if (errNow) begin
          finish = 1'b1;
          nxt    = S_IDLE;
        end else begin
          nxt = S_ERS;
        end
      end
      S_ERS: begin
        stb.issue = 1'b1;
        stb.code  = CMD_ERASE;
        nxt       = S_ERS_W;
      end
      S_ERS_W: if (readyEvt) begin
        if (errNow) begin
          finish = 1'b1;
          nxt    = S_IDLE;
        end else if (opIsWrite) begin
          nxt = S_CLR;
        end else begin
          finish = 1'b1;
          finOk  = 1'b1;
          nxt    = S_IDLE;
        end
      end
      S_CLR: begin
        stb.issue = 1'b1;
        stb.code  = CMD_CLRBUF;
        nxt       = S_CLR_W;
      end
      S_CLR_W: if (flashReady) begin
        if (errNow) begin
          finish = 1'b1;
          nxt    = S_IDLE;
        end else begin
          stb.cntClr = 1'b1;
          nxt        = S_FILL;
        end
      end
      S_FILL: begin
        stb.bufWr   = 1'b1;
        stb.cntStep = 1'b1;
        if (fillLast) nxt = S_WRT;
      end
      S_WRT: begin
        stb.issue = 1'b1;
        stb.code  = CMD_WRITE;
        nxt       = S_WRT_W;
      end
      S_WRT_W: if (readyEvt) begin
        finish = 1'b1;
        finOk  = !errNow;
        nxt    = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      configured <= 1'b0;
      done       <= 1'b0;
      doneOk     <= 1'b0;
      cacheInval <= 1'b0;
    end else begin
      state      <= nxt;
      if (markCfg) configured <= 1'b1;
      done       <= finish;
      doneOk     <= finish & finOk;
      cacheInval <= finish & finOk;
    end
  end

  assign seqIdle   = (state == S_IDLE);
  assign reqReject = anyReq && (state != S_IDLE);

endmodule

// File: rtl/flash_page_seq.sv
module flash_page_seq
  import fsq_pkg::*;
#(
  parameter int PAGE_W     = 16,
  parameter int WAIT_STATE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic              reqErase,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              reqReject,
  output logic              seqIdle,
  output logic              done,
  output logic              doneOk,
  output logic [5:0]        srcIdx,
  input  logic [63:0]       srcData,
  output logic              cmdValid,
  output logic [7:0]        cmdKey,
  output logic [5:0]        cmdCode,
  output logic [PAGE_W-1:0] cmdPage,
  input  logic              flashReady,
  input  logic              readyEvt,
  input  logic              lockErr,
  input  logic              progErr,
  output logic              bufWr,
  output logic [PAGE_W+8:0] bufAddr,
  output logic [63:0]       bufData,
  output logic              cfgWrite,
  output logic              cfgWaitState,
  output logic              cacheInval
);
  seqStrobes_t stb;
  logic opIsWrite, fillLast;

  fsq_control u_ctrl (
    .clk, .rstN, .reqWrite, .reqErase, .flashReady, .readyEvt,
    .lockErr, .progErr, .opIsWrite, .fillLast, .stb,
    .reqReject, .seqIdle, .done, .doneOk, .cacheInval
  );

  fsq_datapath #(.PAGE_W(PAGE_W), .PAGE_BYTES(512), .WORD_BYTES(8)) u_dp (
    .clk, .rstN, .stb, .reqWrite, .reqPage, .srcData, .srcIdx,
    .opIsWrite, .fillLast, .cmdValid, .cmdKey, .cmdCode, .cmdPage,
    .bufWr, .bufAddr, .bufData
  );

  assign cfgWrite     = stb.cfgWr;
  assign cfgWaitState = 1'(WAIT_STATE);

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker (
  input logic clk,
  input logic rstN,
  input logic reqWrite,
  input logic reqErase,
  input logic reqReject,
  input logic seqIdle,
  input logic done,
  input logic doneOk,
  input logic cmdValid,
  input logic bufWr,
  input logic cacheInval
);
  a_r8_inval_only_success: assert property (@(posedge clk) disable iff (!rstN)
    cacheInval |-> (done && doneOk));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> seqIdle);

  a_r9_ok_only_with_done: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |-> done);

  a_r3_reject_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> !seqIdle);

  a_r3_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rstN)
    (seqIdle && (reqWrite || reqErase)) |=> !seqIdle);

  a_r1_cmd_spaced: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  a_r5_fill_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    bufWr |-> !cmdValid);
endmodule

bind flash_page_seq fsq_checker u_chk (.*);

// File: tb/flash_page_seq_tb.sv
`timescale 1ns/1ps
module flash_page_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqWrite = 1'b0, reqErase = 1'b0;
  logic [15:0] reqPage = '0;
  logic reqReject, seqIdle, done, doneOk;
  logic [5:0] srcIdx;
  logic [63:0] srcData;
  logic cmdValid;
  logic [7:0] cmdKey;
  logic [5:0] cmdCode;
  logic [15:0] cmdPage;
  logic flashReady, readyEvt = 1'b0, lockErr, progErr;
  logic bufWr;
  logic [24:0] bufAddr;
  logic [63:0] bufData;
  logic cfgWrite, cfgWaitState, cacheInval;

  always #2.5 clk = ~clk;

  flash_page_seq u_dut (.*);

  function automatic logic [63:0] srcFn(int idx);
    return {32'(idx) * 32'h9E3779B1, ~(32'(idx) ^ 32'h5A5A0F0F)};
  endfunction
  assign srcData = srcFn(int'(srcIdx));

  // flash controller model
  int cyc = 0, logN = 0, bufCnt = 0, bufErr = 0, cfgCnt = 0, keyErr = 0;
  int evCnt = 0, pollCnt = 0, evDelay = 4;
  int logCode[64], logPage[64], logCyc[64];
  logic [5:0] lastCode = '0;
  int errKind = 0;             // 0 none, 1 lock, 2 prog
  logic [5:0] errCode = '0;
  int tbPage = 0, bufBase = 0, logBase = 0;
  int relW, idxW;
  logic [31:0] expA;
  logic [63:0] expD;

  assign flashReady = (pollCnt == 0);
  assign lockErr = (errKind == 1) && (lastCode == errCode);
  assign progErr = (errKind == 2) && (lastCode == errCode);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    readyEvt <= (evCnt == 1);
    if (evCnt != 0) evCnt <= evCnt - 1;
    if (pollCnt != 0) pollCnt <= pollCnt - 1;
    if (rstN && cmdValid) begin
      if (logN < 64) begin
        logCode[logN] <= int'(cmdCode);
        logPage[logN] <= int'(cmdPage);
        logCyc[logN]  <= cyc;
      end
      logN <= logN + 1;
      lastCode <= cmdCode;
      if (cmdKey != 8'hA5) keyErr <= keyErr + 1;
      if (cmdCode == 6'd3 || cmdCode == 6'd16) pollCnt <= 3;
      else evCnt <= evDelay;
    end
    if (rstN && cfgWrite) cfgCnt <= cfgCnt + 1;
    if (rstN && bufWr) begin
      relW = bufCnt - bufBase;
      idxW = relW >> 1;
      expA = 32'(tbPage) * 32'd512 + 32'(idxW) * 32'd8;
      expD = relW[0] ? srcFn(idxW) : 64'hFFFF_FFFF_FFFF_FFFF;
      if (bufAddr != expA[24:0] || bufData != expD || srcIdx != 6'(idxW)) bufErr <= bufErr + 1;
      bufCnt <= bufCnt + 1;
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startOp(input bit w, input bit e, input int page);
    @(negedge clk);
    tbPage = page; bufBase = bufCnt; logBase = logN;
    reqWrite = w; reqErase = e; reqPage = 16'(page);
    @(negedge clk);
    reqWrite = 1'b0; reqErase = 1'b0;
  endtask

  task automatic waitDone(input string req, output bit ok, output bit inv);
    bit seen = 0;
    ok = 0; inv = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1; ok = doneOk; inv = cacheInval;
        chk(seqIdle, {req, "/R9 idle at done"}, seqIdle, 1);
      end
    end
    chk(seen, {req, " done seen"}, seen, 1);
    @(negedge clk);
    chk(!done && !cacheInval, "R9/R8 single-cycle pulses", {done, cacheInval}, 0);
  endtask

  task automatic testReset();
    chk(seqIdle && !done && !cmdValid && !bufWr && !cfgWrite && !cacheInval, "R11 reset outputs",
        {seqIdle, done, cmdValid, bufWr, cfgWrite, cacheInval}, 6'b100000);
  endtask

  task automatic testFirstWrite();
    bit ok, inv;
    evDelay = 4;
    startOp(1, 0, 3);
    waitDone("R1", ok, inv);
    chk(cfgCnt == 1, "R7 one cfg write", cfgCnt, 1);
    chk(cfgWaitState == 1'b1, "R7 wait state", cfgWaitState, 1);
    chk(logN - logBase == 5, "R7 cmd count", logN - logBase, 5);
    chk(logCode[logBase] == 16, "R7 high-speed first", logCode[logBase], 16);
    chk(logCode[logBase+1] == 5 && logPage[logBase+1] == 3, "R1 unlock", logCode[logBase+1], 5);
    chk(logCode[logBase+2] == 2 && logPage[logBase+2] == 3, "R1 erase", logCode[logBase+2], 2);
    chk(logCode[logBase+3] == 3 && logPage[logBase+3] == 0, "R1 clear", logCode[logBase+3], 3);
    chk(logCode[logBase+4] == 1 && logPage[logBase+4] == 3, "R1 write", logCode[logBase+4], 1);
    chk(bufCnt - bufBase == 128, "R5 fill count", bufCnt - bufBase, 128);
    chk(bufErr == 0, "R5 fill addr/data", bufErr, 0);
    chk(ok && inv, "R8 success inval", {ok, inv}, 2'b11);
    chk(keyErr == 0, "R1 key", keyErr, 0);
  endtask

  task automatic testErase();
    bit ok, inv;
    startOp(0, 1, 7);
    waitDone("R2", ok, inv);
    chk(logN - logBase == 2, "R2 cmd count", logN - logBase, 2);
    chk(logCode[logBase] == 5 && logPage[logBase] == 7, "R2 unlock", logCode[logBase], 5);
    chk(logCode[logBase+1] == 2 && logPage[logBase+1] == 7, "R2 erase", logCode[logBase+1], 2);
    chk(bufCnt == bufBase, "R2 no buffer", bufCnt - bufBase, 0);
    chk(ok && inv, "R2/R8 ok", {ok, inv}, 2'b11);
    chk(cfgCnt == 1, "R7 no re-config", cfgCnt, 1);
  endtask

  task automatic testBusy();
    bit ok, inv;
    evDelay = 10;
    startOp(0, 1, 7);
    reqWrite = 1'b1; reqPage = 16'd9;
    #1;
    chk(reqReject, "R3 reject while busy", reqReject, 1);
    @(negedge clk);
    reqWrite = 1'b0;
    waitDone("R3", ok, inv);
    chk(logN - logBase == 2, "R3 no extra cmds", logN - logBase, 2);
    chk(logPage[logBase+1] == 7, "R3 page kept", logPage[logBase+1], 7);
    chk(bufCnt == bufBase, "R3 no buffer writes", bufCnt - bufBase, 0);
    chk(ok, "R3 op completes", ok, 1);
  endtask

  task automatic testSlowEvent();
    bit ok, inv;
    evDelay = 20;
    startOp(1, 0, 16'hFFFF);
    waitDone("R6", ok, inv);
    chk(logCyc[logBase+1] - logCyc[logBase] >= 20, "R6 waits for event",
        logCyc[logBase+1] - logCyc[logBase], 20);
    chk(logCyc[logBase+3] - logCyc[logBase+2] < 140, "R6 clear polled",
        logCyc[logBase+3] - logCyc[logBase+2], 140);
    chk(bufErr == 0 && bufCnt - bufBase == 128, "R5 top page fill", bufErr, 0);
    chk(ok && inv, "R6 ok", {ok, inv}, 2'b11);
    evDelay = 4;
  endtask

  task automatic testErr(input int kind, input logic [5:0] code, input int expCmds);
    bit ok, inv;
    errKind = kind; errCode = code;
    startOp(1, 0, 12);
    waitDone("R4", ok, inv);
    errKind = 0;
    chk(!ok && !inv, "R4 failure reported", {ok, inv}, 0);
    chk(logN - logBase == expCmds, "R4 abort point", logN - logBase, expCmds);
    chk(bufCnt - bufBase == (code == 6'd1 ? 128 : 0), "R4 buffer writes", bufCnt - bufBase, 0);
  endtask

  task automatic testBoth();
    bit ok, inv;
    startOp(1, 1, 5);
    waitDone("R10", ok, inv);
    chk(logN - logBase == 4 && logCode[logBase+3] == 1, "R10 program wins", logN - logBase, 4);
    chk(bufCnt - bufBase == 128 && bufErr == 0, "R10 fill", bufCnt - bufBase, 128);
    chk(ok && inv, "R10 ok", {ok, inv}, 2'b11);
  endtask

  task automatic runAll();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstWrite();
    testErase();
    testBusy();
    testSlowEvent();
    testErr(1, 6'd5, 1);
    testErr(2, 6'd1, 4);
    testErr(1, 6'd3, 3);
    testBoth();
    begin
      bit ok, inv;
      startOp(0, 1, 2);
      waitDone("R4 recovery", ok, inv);
      chk(ok && inv, "R4 recovery after errors", {ok, inv}, 2'b11);
    end
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        chk(0, "WATCHDOG", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule